// File: doc/BRIEF.md
# Preemptible Burst Bus Master

This block is the initiator half of a PCI-style bus master. A local data engine hands it a job (a start address and a word count) and the block turns that job into bus traffic: it asks the arbiter for the bus, and once granted it runs exactly one transaction. That transaction is an address phase carrying the memory-write command, followed by back-to-back data phases whose payload is taken from the engine's write stream.

Losing the grant does not end the burst on its own. The block loads a programmable latency count when it starts driving FRAME and counts it down once per clock. A burst is cut short only when the count has run out and the grant is also gone. In that case the phase in progress is completed, FRAME is dropped, one further data phase is completed, and the bus is released. Any words not yet sent stay queued inside the block and are sent in a later transaction at the following address. A mode input chooses whether REQ falls for the release and rises again at once, or stays high throughout.

The job interface is valid/ready. A job transfers on a clock edge where `job_valid` and `job_ready` are both high, and `job_ready` is high only while the block is idle with no words left over. The write stream has a ready signal only. The engine must present the word for the current data phase on `wdata` for as long as IRDY is high. `wdata_ready` marks the edge on which that word is taken, and the engine moves to the next word after each such edge. All bus pins are modelled active-high.

Top module: `pcib_burst_master`

## Requirements
- R1: During and after reset, `req`, `frame`, `irdy` and `ad_oe` are low and `job_ready` is high.
- R2: A job is taken on an edge with `job_valid` and `job_ready` high. `job_ready` is high only when the bus is idle and no words remain. A job with count 0 is taken and produces no bus activity. After a job with a nonzero count is taken, `req` is high on the next cycle.
- R3: With words pending, an edge that samples `gnt` high while idle starts an address phase. For one cycle `frame` is high, `irdy` is low, `cbe` is 4'b0111 and `ad_out` holds the current word address. `irdy` is high on the following cycle.
- R4: A data phase completes on an edge where `irdy`, `trdy` and `devsel` are all high. In every data phase `ad_out` carries `wdata`, and `wdata_ready` is high exactly in cycles that end in a completion.
- R5: `frame` falls only at a completing edge. If the grant is removed while the latency count is nonzero, the burst continues with `frame` high.
- R6: The latency count loads `lat_cfg` at the edge that raises `frame` and then decrements by one per clock, saturating at 0. If a data phase completes with `frame` high while the count is 0 and `gnt` is low, and at least two more words would remain afterwards, then `frame` is low and `irdy` high in the next cycle.
- R7: When a phase with `frame` low completes, `irdy` falls on the next cycle and the bus returns to idle, with `ad_oe` low.
- R8: When one word remains after a completion, or after the address phase, `frame` falls with `irdy` held high for that final phase. During that final phase `req` is low unless a job with a nonzero count is waiting on `job_valid`.
- R9: With `hold_req` low, `req` is low during the final phase of a preempted burst and is high again in the cycle after the release.
- R10: With `hold_req` high, `req` stays high through the final phase of a preempted burst and through the release.
- R11: Each bus ownership carries exactly one address phase. After a preemption the next address phase carries the address of the first unsent word, which is the start address plus 4 for each word already sent. Across all transactions of a job, the number of completed phases equals the word count.
- R12: During data phases `cbe` carries all-enabled byte enables, 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lat_cfg | input | 8 | Latency count loaded when a transaction starts |
| hold_req | input | 1 | 1: keep REQ high across a preemption release |
| job_valid | input | 1 | Job offered by the data engine |
| job_ready | output | 1 | Block idle with no leftover words; job accepted |
| job_addr | input | 32 | Byte address of the first word of the job |
| job_count | input | 8 | Number of words in the job |
| wdata | input | 32 | Word for the current data phase |
| wdata_ready | output | 1 | Current word is taken at this edge |
| req | output | 1 | Bus request to the arbiter |
| gnt | input | 1 | Bus grant from the arbiter |
| frame | output | 1 | Transaction in progress, more phases follow |
| irdy | output | 1 | Initiator ready in a data phase |
| trdy | input | 1 | Target ready |
| devsel | input | 1 | Target has claimed the transaction |
| cbe | output | 4 | Command in the address phase, byte enables in data phases |
| ad_out | output | 32 | Address or data driven onto the bus |
| ad_oe | output | 1 | Drive enable for the address/data and command lines |

## Verification
The bench goes after the cases where grant removal and latency expiry coincide with the final words of a job. These include a zero latency count with the grant removed at once, bursts of one and two words where a preemption cannot shorten the transfer any further, and removal of the grant while the target is inserting wait states. A design that ends the burst as soon as the grant falls would drop `frame` early. A design that skips the extra phase after preemption would lower `irdy` together with `frame`. A design that lets the wrong mode decide REQ would show the wrong `req` level during the final phase. A resumed transaction that restarts at the job's start address, or that loses or repeats a word, is caught by checking the address in every address phase and the data in every data phase.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_LAST = 2'd3
  } pcib_phase_e;

  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pcib_work_cnt.sv
// Holds the words still owed and the address of the next one.
module pcib_work_cnt #(
  parameter int AW   = 32,
  parameter int CW   = 8,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          beat,
  output logic [CW-1:0] rem_q,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] rem_next
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [AW-1:0] addr_next;

  always_comb begin
    rem_next  = rem_q;
    addr_next = addr_q;
    if (load) begin
      rem_next  = load_cnt;
      addr_next = load_addr;
    end else if (beat) begin
      rem_next  = rem_q - ONE_C;
      addr_next = addr_q + STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else begin
      rem_q  <= rem_next;
      addr_q <= addr_next;
    end
  end
endmodule

// File: rtl/pcib_lat_timer.sv
// Ownership latency count: loads at transaction start, saturates at zero.
module pcib_lat_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] cfg,
  output logic          expired
);
  localparam logic [LW-1:0] ONE_L = LW'(1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= cfg;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE_L;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pcib_phase_fsm.sv
// Bus phase sequencer: idle, address, data, final data phase.
module pcib_phase_fsm
  import pcib_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt,
  input  logic          beat,
  input  logic          lat_zero,
  input  logic [CW-1:0] rem_q,
  output pcib_phase_e   phase_q,
  output pcib_phase_e   phase_d,
  output logic          preempt_d
);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [CW-1:0] TWO_C = CW'(2);

  always_comb begin
    phase_d   = phase_q;
    preempt_d = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (rem_q != '0 && gnt) phase_d = PH_ADDR;
      PH_ADDR: phase_d = (rem_q == ONE_C) ? PH_LAST : PH_DATA;
      PH_DATA: begin
        if (beat) begin
          if (rem_q == TWO_C) begin
            phase_d = PH_LAST;
          end else if (lat_zero && !gnt) begin
            phase_d   = PH_LAST;
            preempt_d = 1'b1;
          end
        end
      end
      PH_LAST: if (beat) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/pcib_req_ctl.sv
// Arbiter request: follows pending work, with a mode for preemption release.
module pcib_req_ctl
  import pcib_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pcib_phase_e   phase_q,
  input  pcib_phase_e   phase_d,
  input  logic          preempt_d,
  input  logic [CW-1:0] rem_next,
  input  logic          hold_req,
  input  logic          job_pend,
  output logic          req_q
);
  logic req_d;

  always_comb begin
    unique case (phase_d)
      PH_IDLE: req_d = (rem_next != '0) || job_pend;
      PH_ADDR,
      PH_DATA: req_d = 1'b1;
      PH_LAST: begin
        if (phase_q == PH_LAST) req_d = req_q;
        else if (preempt_d)     req_d = hold_req;
        else                    req_d = job_pend;
      end
      default: req_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/pcib_burst_master.sv
module pcib_burst_master
  import pcib_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int LAT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LAT_W-1:0]      lat_cfg,
  input  logic                  hold_req,
  input  logic                  job_valid,
  output logic                  job_ready,
  input  logic [ADDR_W-1:0]     job_addr,
  input  logic [CNT_W-1:0]      job_count,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  wdata_ready,
  output logic                  req,
  input  logic                  gnt,
  output logic                  frame,
  output logic                  irdy,
  input  logic                  trdy,
  input  logic                  devsel,
  output logic [DATA_W/8-1:0]   cbe,
  output logic [ADDR_W-1:0]     ad_out,
  output logic                  ad_oe
);
  localparam int CBE_W = DATA_W / 8;
  localparam int STEP  = DATA_W / 8;
  localparam logic [CBE_W-1:0] BE_ALL = '0;
  localparam logic [CBE_W-1:0] CMD_V  = CBE_W'(CMD_MEM_WR);

  pcib_phase_e   phase_q, phase_d;
  logic          preempt_d;
  logic          beat, lat_zero, job_fire, job_pend, tx_start;
  logic [CNT_W-1:0]  rem_q, rem_next;
  logic [ADDR_W-1:0] addr_q;

  assign job_ready = (phase_q == PH_IDLE) && (rem_q == '0);
  assign job_fire  = job_valid && job_ready;
  assign job_pend  = job_valid && (job_count != '0);
  assign irdy      = (phase_q == PH_DATA) || (phase_q == PH_LAST);
  assign frame     = (phase_q == PH_ADDR) || (phase_q == PH_DATA);
  assign ad_oe     = (phase_q != PH_IDLE);
  assign beat      = irdy && trdy && devsel;
  assign wdata_ready = beat;
  assign tx_start  = (phase_q == PH_IDLE) && (phase_d == PH_ADDR);

  assign cbe    = (phase_q == PH_ADDR) ? CMD_V : BE_ALL;
  assign ad_out = (phase_q == PH_ADDR) ? addr_q : ADDR_W'(wdata);

  pcib_work_cnt #(.AW(ADDR_W), .CW(CNT_W), .STEP(STEP)) u_work (
    .clk(clk), .rst_n(rst_n), .load(job_fire), .load_addr(job_addr),
    .load_cnt(job_count), .beat(beat), .rem_q(rem_q), .addr_q(addr_q),
    .rem_next(rem_next)
  );

  pcib_lat_timer #(.LW(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(tx_start), .cfg(lat_cfg), .expired(lat_zero)
  );

  pcib_phase_fsm #(.CW(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .beat(beat), .lat_zero(lat_zero),
    .rem_q(rem_q), .phase_q(phase_q), .phase_d(phase_d), .preempt_d(preempt_d)
  );

  pcib_req_ctl #(.CW(CNT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_d(phase_d),
    .preempt_d(preempt_d), .rem_next(rem_next), .hold_req(hold_req),
    .job_pend(job_pend), .req_q(req)
  );
endmodule

// File: rtl/pcib_burst_master_chk.sv
module pcib_burst_master_chk #(
  parameter int CW    = 8,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_req,
  input logic             job_valid,
  input logic             job_ready,
  input logic             req,
  input logic             gnt,
  input logic             frame,
  input logic             irdy,
  input logic             trdy,
  input logic             devsel,
  input logic [CBE_W-1:0] cbe,
  input logic             ad_oe,
  input logic             lat_zero,
  input logic [CW-1:0]    rem_q
);
  localparam logic [CW-1:0] TWO_C = CW'(2);
  logic done_ph, cut;
  assign done_ph = irdy && trdy && devsel;
  assign cut     = frame && done_ph && lat_zero && !gnt && (rem_q > TWO_C);

  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> (!frame && !irdy && !ad_oe));
  a_r3_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !irdy) |-> (cbe == CBE_W'(4'b0111)));
  a_r3_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !irdy) |=> irdy);
  a_r5_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && irdy && !done_ph) |=> frame);
  a_r6_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    cut |=> (!frame && irdy));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame && irdy && done_ph) |=> (!irdy && !frame));
  a_r9_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cut && !hold_req && !job_valid) |=> !req);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cut && hold_req) |=> req);
  a_r12_be: assert property (@(posedge clk) disable iff (!rst_n)
    irdy |-> (cbe == '0));
endmodule

bind pcib_burst_master pcib_burst_master_chk #(.CW(CNT_W), .CBE_W(DATA_W/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .job_valid(job_valid),
  .job_ready(job_ready), .req(req), .gnt(gnt), .frame(frame), .irdy(irdy),
  .trdy(trdy), .devsel(devsel), .cbe(cbe), .ad_oe(ad_oe),
  .lat_zero(lat_zero), .rem_q(rem_q)
);

// File: tb/pcib_burst_master_tb.sv
module pcib_burst_master_tb;
  localparam int NJOBS = 90;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lat_cfg = '0;
  logic        hold_req = 1'b0;
  logic        job_valid = 1'b0;
  logic        job_ready;
  logic [31:0] job_addr = '0;
  logic [7:0]  job_count = '0;
  logic [31:0] wdata = '0;
  logic        wdata_ready;
  logic        req;
  logic        gnt = 1'b0;
  logic        frame, irdy;
  logic        trdy = 1'b0;
  logic        devsel = 1'b0;
  logic [3:0]  cbe;
  logic [31:0] ad_out;
  logic        ad_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pcib_burst_master u_dut (
    .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg), .hold_req(hold_req),
    .job_valid(job_valid), .job_ready(job_ready), .job_addr(job_addr),
    .job_count(job_count), .wdata(wdata), .wdata_ready(wdata_ready),
    .req(req), .gnt(gnt), .frame(frame), .irdy(irdy), .trdy(trdy),
    .devsel(devsel), .cbe(cbe), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wfun(input int id, input int j);
    return {id[15:0], j[15:0]} ^ 32'h5A5A_0000;
  endfunction

  initial begin
    int cyc = 0, issued = 0, finished = 0, job_id = 0;
    int total = 0, done = 0, since = 0, cfg_i = 0;
    logic [31:0] base = '0;
    bit p_on = 0, p_frame = 0, p_irdy = 0, p_req_on = 0, p_req = 0;
    bit p_jr_on = 0, p_jr = 0;
    string p_tag = "", p_req_tag = "";
    bit o_frame, o_irdy, o_req, o_jr, bt, accept, g = 0, dv = 0;
    logic [7:0] n_cnt, n_cfg;
    bit n_hold;
    int rem;

    repeat (3) @(negedge clk);
    chk(req == 0 && frame == 0 && irdy == 0 && ad_oe == 0 && job_ready == 1,
        "R1 reset state", {27'd0, req, frame, irdy, ad_oe, job_ready}, 32'h1);
    rst_n = 1'b1;

    while (finished < NJOBS && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      o_frame = frame; o_irdy = irdy; o_req = req; o_jr = job_ready;
      if (p_on) begin
        chk(frame == p_frame, {p_tag, " frame"}, 32'(frame), 32'(p_frame));
        chk(irdy == p_irdy, {p_tag, " irdy"}, 32'(irdy), 32'(p_irdy));
      end
      if (p_req_on) chk(req == p_req, {p_req_tag, " req"}, 32'(req), 32'(p_req));
      if (p_jr_on) chk(job_ready == p_jr, "R2 job_ready after accept", 32'(job_ready), 32'(p_jr));
      if (!o_frame && !o_irdy && p_on) chk(ad_oe == 0, "R7 ad_oe idle", 32'(ad_oe), 0);
      if (o_frame && !o_irdy) begin
        chk(cbe == 4'b0111, "R3 command", 32'(cbe), 32'h7);
        chk(ad_out == base + 32'(4 * done), "R11 address phase", ad_out, base + 32'(4 * done));
        since = 0;
      end else if (o_frame || o_irdy) begin
        since++;
      end

      // stimulus
      job_valid = 1'b0;
      accept = 0;
      if (o_req || g) g = g ? ($urandom % 6 != 0) : ($urandom % 3 != 0);
      else g = 0;
      dv = (o_frame || o_irdy) ? (dv || ($urandom % 2 == 0)) : 1'b0;
      trdy = o_irdy && dv && ($urandom % 4 != 0);
      devsel = dv;
      gnt = g;
      if (o_jr && issued < NJOBS && ($urandom % 3 == 0)) begin
        case (issued)
          0: begin n_cnt = 1; n_cfg = 0; n_hold = 0; end
          1: begin n_cnt = 0; n_cfg = 0; n_hold = 0; end
          2: begin n_cnt = 2; n_cfg = 0; n_hold = 0; end
          3: begin n_cnt = 9; n_cfg = 0; n_hold = 1; end
          4: begin n_cnt = 9; n_cfg = 0; n_hold = 0; end
          5: begin n_cnt = 3; n_cfg = 1; n_hold = 1; end
          default: begin
            n_cnt = 8'($urandom % 14); n_cfg = 8'($urandom % 8); n_hold = 1'($urandom);
          end
        endcase
        job_valid = 1'b1; job_count = n_cnt; lat_cfg = n_cfg; hold_req = n_hold;
        job_addr = {$urandom} & 32'hFFFF_FFFC;
        accept = 1;
      end
      wdata = wfun(job_id, done);

      // prediction for the next cycle
      bt = o_irdy && trdy && devsel;
      rem = total - done;
      p_on = 1; p_req_on = 0; p_jr_on = 0;
      if (!o_frame && !o_irdy) begin
        p_irdy = 0;
        if (accept) begin
          p_frame = 0; p_tag = "R2 accept";
          p_req_on = 1; p_req = (n_cnt != 0); p_req_tag = "R2";
          p_jr_on = 1; p_jr = (n_cnt == 0);
        end else if (rem > 0 && g) begin
          p_frame = 1; p_tag = "R3 start";
        end else begin
          p_frame = 0; p_tag = "R11 stay idle";
          if (rem > 0) begin p_req_on = 1; p_req = 1; p_req_tag = "R9 pending"; end
        end
      end else if (o_frame && !o_irdy) begin
        p_irdy = 1; p_frame = (rem >= 2); p_tag = "R3 to data";
        if (rem < 2) begin p_req_on = 1; p_req = 0; p_req_tag = "R8 single"; end
      end else if (o_frame) begin
        p_irdy = 1;
        if (!bt) begin
          p_frame = 1; p_tag = g ? "R4 wait" : "R5 wait no grant";
        end else if (rem - 1 == 1) begin
          p_frame = 0; p_tag = "R8 normal end";
          p_req_on = 1; p_req = 0; p_req_tag = "R8";
        end else if (since >= cfg_i && !g) begin
          p_frame = 0; p_tag = "R6 preempt";
          p_req_on = 1; p_req = hold_req;
          p_req_tag = hold_req ? "R10 hold" : "R9 drop";
        end else begin
          p_frame = 1; p_tag = g ? "R4 continue" : "R5 grant gone timer live";
        end
      end else begin
        p_frame = 0;
        if (bt) begin
          p_irdy = 0; p_tag = "R7 release";
          p_req_on = 1; p_req = (rem - 1 > 0);
          p_req_tag = hold_req ? "R10 after release" : "R9 re-request";
        end else begin
          p_irdy = 1; p_tag = "R7 last wait";
        end
      end

      #1;
      chk(wdata_ready == bt, "R4 wdata_ready", 32'(wdata_ready), 32'(bt));
      if (o_irdy) begin
        chk(ad_out == wdata, "R4 data on bus", ad_out, wdata);
        chk(cbe == 4'b0000, "R12 byte enables", 32'(cbe), 32'h0);
      end
      if (bt) begin
        done++;
        if (done == total) begin
          finished++;
          chk(!o_frame, "R11 word count", 32'(done), 32'(total));
        end
      end
      if (accept) begin
        issued++; job_id++;
        base = job_addr; total = n_cnt; done = 0; cfg_i = n_cfg;
        if (n_cnt == 0) finished++;
      end
    end

    if (cyc >= LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", finished, NJOBS);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule